// File: doc/BRIEF.md
# I2C Two-Port Input Expander (Read Path)

This block is an I2C target that presents two 8-bit input ports as one register pair. A controller first writes a command byte that picks where in the pair a read begins. It then issues a repeated START with the read bit set and clocks out data bytes. Each byte holds the pin values captured in the acknowledge phase just before it, and successive bytes alternate between the two ports for as long as the controller keeps acknowledging.

SCL and SDA are brought into the system clock domain through two-flop synchronizers. START and STOP are recognised from SDA edges while SCL is high. The target drives SDA only by pulling it low, shown as `sda_oe_o`, and changes that drive only while SCL is low. An active-low interrupt reports that a port pin differs from the value last read from that port. Reading that port clears the difference.

Top module: `i2c_port_expander`

## Requirements
- R1: After a START, the target pulls SDA low in the 9th clock when bits 1 to 7 (sent MSB first) equal `DEV_ADDR`. The 8th bit is R/W, with 1 meaning read.
- R2: For any other address the target never drives SDA, and it stays released for the rest of that byte and beyond, until the next START.
- R3: In a write transfer, the first data byte is the command byte and is acknowledged. Its bit 0 picks the starting byte: 0 selects port 0 and 1 selects port 1. Its other bits and any further write bytes are acknowledged and have no effect.
- R4: In a read transfer, the first data byte is the port chosen by the command, sent MSB first. Each bit is valid while SCL is high.
- R5: As long as the controller acknowledges (SDA low in the 9th clock), each following byte comes from the other port of the pair, so the order alternates.
- R6: The pins for each byte are captured at the falling SCL edge that ends the acknowledge clock before that byte. A pin change during a byte shows up only in a later byte.
- R7: After the controller does not acknowledge (SDA high in the 9th clock), the target releases SDA and sends nothing more until a new START.
- R8: A STOP at any point ends the transfer and releases SDA. A command byte cut short by STOP leaves the selection unchanged, and the next transfer works normally.
- R9: The command selection is kept across STOP. A read with no command byte in front of it starts at the last selected port.
- R10: `irq_no_o` goes low when any pin of a port differs from the value last read from that port. After reset, the pin values at reset count as already read.
- R11: `irq_no_o` returns high once every differing port has been read (captured for transmission). Reading only one of two changed ports keeps it low.
- R12: During reset and right after it, `sda_oe_o` is 0 and `irq_no_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| port0_i | input | 8 | Input port 0 pins |
| port1_i | input | 8 | Input port 1 pins |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| irq_no_o | output | 1 | Interrupt, active low |

## Verification
The bench targets these corner cases:
- Pins that change in the middle of a byte. A design that samples them late would let the new value leak into the byte already in flight.
- A read that starts at port 1. A wrong toggle would repeat a port or start at port 0.
- A wrong address. A careless matcher acknowledges it or drives data.
- STOPs that cut into a command byte and into a read. A design that commits partial bytes would move the pointer, and one that does not reset would keep SDA held.
- Two ports that change but only one is read. A design that clears the interrupt for any read would release it too early.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int BYTE_W = 8;
  localparam int NPORT  = 2;
  localparam int SEL_W  = $clog2(NPORT);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/pexp_bus_sync.sv
module pexp_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL held high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/pexp_tgt_fsm.sv
module pexp_tgt_fsm
  import pexp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic              wr_first_o,
  output logic              wr_lsb_o,
  output logic              ld_first_o,
  output logic              ld_next_o,
  output logic              addr_hit_o
);
  tgt_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, ack_q, first_q, oe_q;
  logic              byte_done;

  assign byte_done  = scl_fall_i && (bit_cnt_q == 4'd8);
  assign addr_hit_o = (state_q == ST_ADDR) && byte_done && (sh_q[7:1] == DEV_ADDR);
  assign wr_stb_o   = (state_q == ST_WR) && byte_done;
  assign wr_first_o = first_q;
  assign wr_lsb_o   = sh_q[0];
  assign ld_first_o = (state_q == ST_ADDR_ACK) && scl_fall_i && rw_q;
  assign ld_next_o  = (state_q == ST_RD_ACK) && scl_fall_i && ack_q;
  assign sda_oe_o   = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      ack_q     <= 1'b0;
      first_q   <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
      first_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_q      <= {sh_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              state_q <= ST_ADDR_ACK;
              oe_q    <= 1'b1;
              rw_q    <= sh_q[0];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              sh_q    <= tx_byte_i;
              oe_q    <= ~tx_byte_i[BYTE_W-1];
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise_i) begin
            sh_q      <= {sh_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            oe_q    <= 1'b1;
            state_q <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            first_q   <= 1'b0;
            state_q   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (bit_cnt_q == 4'd7) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_RD_ACK;
            end else begin
              sh_q      <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q      <= ~sh_q[BYTE_W-2];
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            ack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (ack_q) begin
              sh_q      <= tx_byte_i;
              oe_q      <= ~tx_byte_i[BYTE_W-1];
              bit_cnt_q <= '0;
              state_q   <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pexp_port_regs.sv
module pexp_port_regs
  import pexp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NPORT*BYTE_W-1:0] pins_i,
  input  logic                    wr_stb_i,
  input  logic                    wr_first_i,
  input  logic                    wr_lsb_i,
  input  logic                    ld_first_i,
  input  logic                    ld_next_i,
  output logic [BYTE_W-1:0]       tx_byte_o,
  output logic                    irq_no_o
);
  logic [NPORT-1:0][BYTE_W-1:0] pin_q, ref_q;
  logic [NPORT-1:0]             diff;
  logic [SEL_W-1:0]             cmd_sel_q, rd_sel_q, sel_now;
  logic                         primed_q, irq_nq;

  assign sel_now   = ld_first_i ? cmd_sel_q : ~rd_sel_q;
  assign tx_byte_o = pin_q[sel_now];
  assign irq_no_o  = irq_nq;

  for (genvar g = 0; g < NPORT; g++) begin : g_cmp
    assign diff[g] = |(pin_q[g] ^ ref_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q     <= '0;
      ref_q     <= '0;
      cmd_sel_q <= '0;
      rd_sel_q  <= '0;
      primed_q  <= 1'b0;
      irq_nq    <= 1'b1;
    end else begin
      pin_q    <= pins_i;
      primed_q <= 1'b1;
      // first clock out of reset: current pins count as already read
      if (!primed_q) ref_q <= pins_i;
      else if (ld_first_i || ld_next_i) ref_q[sel_now] <= pin_q[sel_now];
      if (wr_stb_i && wr_first_i) cmd_sel_q <= SEL_W'(wr_lsb_i);
      if (ld_first_i || ld_next_i) rd_sel_q <= sel_now;
      irq_nq <= ~(primed_q & (|diff));
    end
  end
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
  import pexp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] port0_i,
  input  logic [BYTE_W-1:0] port1_i,
  output logic              sda_oe_o,
  output logic              irq_no_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic wr_stb, wr_first, wr_lsb, ld_first, ld_next, addr_hit;
  logic [BYTE_W-1:0] tx_byte;

  pexp_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  pexp_tgt_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .tx_byte_i(tx_byte),
    .sda_oe_o, .wr_stb_o(wr_stb), .wr_first_o(wr_first), .wr_lsb_o(wr_lsb),
    .ld_first_o(ld_first), .ld_next_o(ld_next), .addr_hit_o(addr_hit)
  );

  pexp_port_regs i_regs (
    .clk_i, .rst_ni,
    .pins_i({port1_i, port0_i}),
    .wr_stb_i(wr_stb), .wr_first_i(wr_first), .wr_lsb_i(wr_lsb),
    .ld_first_i(ld_first), .ld_next_i(ld_next),
    .tx_byte_o(tx_byte), .irq_no_o
  );
endmodule

// File: rtl/i2c_port_expander_chk.sv
module i2c_port_expander_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start,
  input logic stop,
  input logic addr_hit,
  input logic wr_stb,
  input logic ld_first,
  input logic ld_next,
  input logic sda_oe_o
);
  p_oe_scl_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sda_oe_o) |-> !scl_s);
  p_start_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !sda_oe_o);
  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !sda_oe_o);
  p_addr_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hit |=> sda_oe_o);
  p_one_event_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_stb, ld_first, ld_next}));
  p_load_needs_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_first || ld_next) |-> !scl_s);
endmodule

bind i2c_port_expander i2c_port_expander_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start(start), .stop(stop),
  .addr_hit(addr_hit), .wr_stb(wr_stb), .ld_first(ld_first), .ld_next(ld_next),
  .sda_oe_o(sda_oe_o)
);

// File: tb/test_i2c_port_expander.sv
module test_i2c_port_expander;
  localparam logic [6:0] ADDR = 7'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, csda = 1'b1;
  logic [7:0] p0 = 8'h5A, p1 = 8'hC3;
  logic sda_oe, irq_n;
  wire  sda_bus = csda & ~sda_oe;
  int nvec = 0, nerr = 0;
  logic m_cmd = 1'b0;
  logic [7:0] m_ref0, m_ref1;

  always #2 clk = ~clk;

  i2c_port_expander i_i2c_port_expander (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .port0_i(p0), .port1_i(p1), .sda_oe_o(sda_oe), .irq_no_o(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (8) @(negedge clk); endtask
  task automatic bit_out(input logic b);
    csda = b; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
  endtask
  task automatic bit_in(output logic b);
    csda = 1'b1; hp(); scl = 1'b1; hp(); b = sda_bus; scl = 1'b0; hp();
  endtask
  task automatic start_c();
    csda = 1'b1; hp(); scl = 1'b1; hp(); csda = 1'b0; hp(); scl = 1'b0; hp();
  endtask
  task automatic stop_c();
    csda = 1'b0; hp(); scl = 1'b1; hp(); csda = 1'b1; hp(); hp();
  endtask
  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask
  task automatic rd_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~ack);
  endtask

  function automatic int irq_exp();
    return ((p0 != m_ref0) || (p1 != m_ref1)) ? 0 : 1;
  endfunction

  // read n bytes; with_cmd writes cmd first then repeated START
  task automatic rd_seq(input int n, input bit with_cmd, input logic [7:0] cmd,
                        input string req);
    logic a;
    logic [7:0] d, e;
    logic sel;
    start_c();
    if (with_cmd) begin
      wr_byte({ADDR, 1'b0}, a); chk("R1 write addr ack", a, 1);
      wr_byte(cmd, a);          chk("R3 cmd ack", a, 1);
      m_cmd = cmd[0];
      start_c();
    end
    wr_byte({ADDR, 1'b1}, a); chk("R1 read addr ack", a, 1);
    sel = m_cmd;
    for (int k = 0; k < n; k++) begin
      e = sel ? p1 : p0;
      if (sel) m_ref1 = e; else m_ref0 = e;
      rd_byte(k != n - 1, d);
      chk(req, d, e);
      sel = ~sel;
    end
    chk("R7 released after NACK", sda_oe, 0);
    stop_c();
    chk("R8 idle after STOP", sda_oe, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : stim
    logic a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    chk("R12 oe in reset", sda_oe, 0);
    chk("R12 irq in reset", irq_n, 1);
    rst_n = 1'b1;
    m_ref0 = p0; m_ref1 = p1;
    hp();
    chk("R12 oe after reset", sda_oe, 0);
    chk("R12 irq after reset", irq_n, 1);

    // R3 R4 R5: cmd 0, four alternating bytes
    rd_seq(4, 1'b1, 8'h00, "R5 alternate from port0");
    // R3: cmd bit0=1 with junk upper bits, extra write byte ignored
    start_c();
    wr_byte({ADDR, 1'b0}, a); chk("R1 ack", a, 1);
    wr_byte(8'hF1, a);        chk("R3 cmd ack", a, 1);
    wr_byte(8'h00, a);        chk("R3 extra byte ack", a, 1);
    m_cmd = 1'b1;
    stop_c();
    rd_seq(3, 1'b0, 8'h00, "R3 start at port1 ignoring extra byte");
    // R9: pointer survives STOP
    rd_seq(2, 1'b0, 8'h00, "R9 resume at port1");

    // R2: wrong address
    start_c();
    wr_byte({7'h21, 1'b1}, a); chk("R2 no ack", a, 0);
    rd_byte(1'b0, d);          chk("R2 SDA never driven", d, 8'hFF);
    stop_c();

    // R10 R11
    p0 = 8'h11; hp(); hp();
    chk("R10 irq on port0 change", irq_n, 0);
    rd_seq(1, 1'b0, 8'h00, "R11 read port1 only");
    hp();
    chk("R11 irq stays, port0 unread", irq_n, irq_exp());
    chk("R11 irq stays low", irq_n, 0);
    rd_seq(2, 1'b0, 8'h00, "R11 read both");
    hp();
    chk("R11 irq cleared", irq_n, 1);
    p1 = 8'h3C; hp(); hp();
    chk("R10 irq on port1 change", irq_n, 0);
    rd_seq(1, 1'b0, 8'h00, "R11 read port1");
    hp();
    chk("R11 irq cleared by port1", irq_n, 1);

    // R6: change port0 in mid-byte
    start_c();
    wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h00, a); m_cmd = 1'b0;
    start_c();
    wr_byte({ADDR, 1'b1}, a); chk("R1 ack", a, 1);
    for (int i = 7; i >= 0; i--) begin
      bit_in(d[i]);
      if (i == 4) p0 = 8'h77;
    end
    bit_out(1'b0);
    chk("R6 in-flight byte keeps old pins", d, 8'h11);
    rd_byte(1'b1, d); chk("R6 port1 byte", d, 8'h3C);
    rd_byte(1'b0, d); chk("R6 new pins in later byte", d, 8'h77);
    m_ref0 = 8'h77; m_ref1 = 8'h3C;
    stop_c();
    hp();
    chk("R11 irq after reading new pins", irq_n, irq_exp());

    // R8: STOP inside a command byte leaves pointer at 0
    start_c();
    wr_byte({ADDR, 1'b0}, a);
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
    stop_c();
    chk("R8 oe after abort", sda_oe, 0);
    rd_seq(2, 1'b0, 8'h00, "R8 pointer unchanged by aborted cmd");

    // R8: STOP in mid-read (bit4 of 0x77 is 1, so SDA free)
    start_c();
    wr_byte({ADDR, 1'b1}, a); chk("R1 ack", a, 1);
    m_ref0 = p0;
    bit_in(d[7]); bit_in(d[6]); bit_in(d[5]);
    chk("R4 msb bits", d[7:5], 3'b011);
    stop_c();
    chk("R8 released after mid-read STOP", sda_oe, 0);
    rd_seq(2, 1'b1, 8'h01, "R8 clean transfer after abort");
    hp();
    chk("R10 irq idle", irq_n, irq_exp());

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule